// File: doc/BRIEF.md
# Board interrupt level encoder

This block collects thirteen level-sensitive interrupt request lines from the peripherals on a board. It sets each request into its own bit of a 16-bit pending word and gates that word with a software mask. The surviving request with the smallest priority level is presented to the processor as a 4-bit code, inverted so that zero means "nothing pending".

A small 16-bit register port sits alongside the encoder, decoded over a 64-byte byte-addressed window. It holds the interrupt mask, a general-purpose output latch, a fixed identification value and a write-triggered power-off request. Accesses take one cycle. Read data appears on the cycle after the strobe.

Top module: `board_irq_level_enc`

## Requirements
- R1: A pending bit is set while its request input is high and clear while it is low. It does not latch, so dropping a request removes it from arbitration.
- R2: Each request input index maps to a fixed pair of (level, pending bit): 0 compact-flash disk (1, 9); 1 card insert (2, 8); 2 PCI INTA (9, 14); 3 PCI INTB (10, 13); 4 PCI INTC (3, 12); 5 PCI INTD (0, 11); 6 display (4, 10); 7 keyboard (5, 6); 8 clock alarm (6, 5); 9 clock tick (7, 4); 10 SD card (8, 7); 11 external (11, 0); 12 touch panel (12, 15).
- R3: A source competes only when its pending bit and the matching mask bit are both 1. Among the competing sources, the smallest level wins.
- R4: `irl_code` equals the winning level XOR 15. When no source competes, the selected level is 15 and `irl_code` is 0.
- R5: `irl_code` is registered. It reflects a request change, or a mask write, on the first clock edge after that change.
- R6: The mask at offset 0x00 and the output latch at offset 0x36 can be written and read back. Both reset to 0, and `irl_code` resets to 0.
- R7: A write to offset 0x30 with data bit 0 set raises `shutdown` for exactly one cycle. A write there with bit 0 clear raises nothing. A read of offset 0x30 returns 0.
- R8: A read of offset 0x32 always returns 0x0010. Writes to offset 0x32 change nothing.
- R9: A read of any other offset returns 0. A write to any other offset leaves the mask, the output latch and `irl_code` unchanged.
- R10: `rdata` is loaded on the clock edge that samples `rd_en`. It holds its value while no read is strobed. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 13 | Request levels, indexed as in R2, synchronous to clk |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 6 | Byte offset in the 64-byte window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| irl_code | output | 4 | Inverted level of the winning request; 0 means none |
| shutdown | output | 1 | One-cycle power-off request |

## Verification
Each of the three results arrives exactly one edge after its cause:
- `irl_code` after a request change or a mask write;
- `rdata` after the read strobe;
- `shutdown` after the power-off write.

The bench drives inputs on falling edges and samples just after the next rising edge. It also samples once before that edge, to show that `irl_code` has not yet moved. The shutdown pulse is checked in the cycle of the write and again in the following cycle, which shows both that it rises and that it drops.

// File: rtl/board_irq_level_enc.sv
module board_irq_level_enc #(
  parameter int NSRC   = 13,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [LVL_W-1:0]  irl_code,
  output logic              shutdown
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(6'h00);
  localparam logic [ADDR_W-1:0] OFF_PWR  = ADDR_W'(6'h30);
  localparam logic [ADDR_W-1:0] OFF_ID   = ADDR_W'(6'h32);
  localparam logic [ADDR_W-1:0] OFF_GPO  = ADDR_W'(6'h36);
  localparam logic [DATA_W-1:0] ID_VAL   = DATA_W'(16'h0010);
  localparam logic [LVL_W-1:0]  NONE_LVL = {LVL_W{1'b1}};

  function automatic logic [LVL_W-1:0] src_level(input int i);
    case (i)
      0: return LVL_W'(1);   1: return LVL_W'(2);   2: return LVL_W'(9);
      3: return LVL_W'(10);  4: return LVL_W'(3);   5: return LVL_W'(0);
      6: return LVL_W'(4);   7: return LVL_W'(5);   8: return LVL_W'(6);
      9: return LVL_W'(7);   10: return LVL_W'(8);  11: return LVL_W'(11);
      12: return LVL_W'(12);
      default: return NONE_LVL;
    endcase
  endfunction

  function automatic int src_bit(input int i);
    case (i)
      0: return 9;   1: return 8;   2: return 14;  3: return 13;
      4: return 12;  5: return 11;  6: return 10;  7: return 6;
      8: return 5;   9: return 4;   10: return 7;  11: return 0;
      12: return 15;
      default: return 0;
    endcase
  endfunction

  logic [DATA_W-1:0] mask_q, gpo_q, mon, mask_nxt, live;
  logic [LVL_W-1:0]  best;

  wire wr_mask = wr_en && (addr == OFF_MASK);
  wire wr_gpo  = wr_en && (addr == OFF_GPO);
  wire wr_pwr  = wr_en && (addr == OFF_PWR) && wdata[0];

  assign mask_nxt = wr_mask ? wdata : mask_q;
  assign live     = mon & mask_nxt;

  always_comb begin
    mon = '0;
    for (int i = 0; i < NSRC; i++)
      if (req[i]) mon[src_bit(i)] = 1'b1;
  end

  always_comb begin
    best = NONE_LVL;
    for (int i = 0; i < NSRC; i++)
      if (live[src_bit(i)] && (src_level(i) < best)) best = src_level(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      gpo_q    <= '0;
      irl_code <= '0;
      shutdown <= 1'b0;
      rdata    <= '0;
    end else begin
      mask_q   <= mask_nxt;
      if (wr_gpo) gpo_q <= wdata;
      irl_code <= best ^ NONE_LVL;
      shutdown <= wr_pwr;
      if (rd_en) begin
        case (addr)
          OFF_MASK: rdata <= mask_q;
          OFF_GPO:  rdata <= gpo_q;
          OFF_ID:   rdata <= ID_VAL;
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/board_irq_level_enc_chk.sv
module board_irq_level_enc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] req,
  input logic        wr_en,
  input logic        rd_en,
  input logic [5:0]  addr,
  input logic [15:0] wdata,
  input logic [15:0] rdata,
  input logic [3:0]  irl_code,
  input logic        shutdown,
  input logic [15:0] mask_q
);
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req == 13'd0) |=> (irl_code == 4'd0)); // R4
  AST_MASK_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 6'h00 && wdata == 16'h0000) |=> (irl_code == 4'd0)); // R3
  AST_TOP_LEVEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req[5] && mask_q[11] && !wr_en) |=> (irl_code == 4'd15)); // R2
  AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> $past(wr_en && addr == 6'h30 && wdata[0])); // R7
  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 6'h32) |=> (rdata == 16'h0010)); // R8
  AST_PWR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 6'h30) |=> (rdata == 16'h0000)); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && $past(rst_n)) |=> $stable(rdata)); // R10
endmodule

bind board_irq_level_enc board_irq_level_enc_chk u_chk (.*);

// File: tb/tb_board_irq_level_enc.sv
`timescale 1ns/1ps
module tb_board_irq_level_enc;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [12:0] req = '0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  irl_code;
  logic        shutdown;
  int checks = 0, failures = 0;
  bit done = 0;

  localparam int LVL [13] = '{1, 2, 9, 10, 3, 0, 4, 5, 6, 7, 8, 11, 12};
  localparam int BIT [13] = '{9, 8, 14, 13, 12, 11, 10, 6, 5, 4, 7, 0, 15};

  always #4 clk = ~clk;

  board_irq_level_enc dut (.*);

  function automatic logic [3:0] model(input logic [12:0] r, input logic [15:0] m);
    int b = 15;
    for (int i = 0; i < 13; i++)
      if (r[i] && m[BIT[i]] && LVL[i] < b) b = LVL[i];
    return 4'(b) ^ 4'hF;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic set_req(input logic [12:0] r);
    @(negedge clk); req = r;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R6 irl reset", 16'(irl_code), 0);
    chk("R10 rdata reset", rdata, 0);
    chk("R7 shutdown reset", 16'(shutdown), 0);
    rd(6'h00, d); chk("R6 mask reset", d, 0);
    rd(6'h36, d); chk("R6 gpo reset", d, 0);
    set_req(13'h1FFF); chk("R3 all masked", 16'(irl_code), 0);
    set_req(0);
  endtask

  task automatic t_single();
    wr(6'h00, 16'hFFFF);
    for (int i = 0; i < 13; i++) begin
      set_req(13'(1) << i);
      chk($sformatf("R2 source %0d", i), 16'(irl_code), 16'(model(13'(1) << i, 16'hFFFF)));
      chk($sformatf("R4 source %0d code", i), 16'(irl_code), 16'(LVL[i] ^ 15));
    end
    set_req(0); chk("R4 none", 16'(irl_code), 0);
  endtask

  task automatic t_priority();
    logic [12:0] r;
    r = (13'(1) << 2) | (13'(1) << 11); set_req(r);
    chk("R3 9 vs 11", 16'(irl_code), 16'(9 ^ 15));
    r |= 13'(1) << 7; set_req(r);
    chk("R3 add level5", 16'(irl_code), 16'(5 ^ 15));
    r |= 13'(1) << 5; set_req(r);
    chk("R3 level0 wins", 16'(irl_code), 15);
    wr(6'h00, 16'hF7FF);
    chk("R3 mask out level0", 16'(irl_code), 16'(5 ^ 15));
    wr(6'h00, 16'h0001);
    chk("R3 only external", 16'(irl_code), 16'(11 ^ 15));
    wr(6'h00, 16'hFFFF);
    r &= ~(13'(1) << 5); set_req(r);
    chk("R1 drop level0", 16'(irl_code), 16'(5 ^ 15));
    set_req(0);
  endtask

  task automatic t_timing();
    @(negedge clk); req = 13'(1) << 0;
    #1 chk("R5 before edge", 16'(irl_code), 0);
    @(posedge clk); #1 chk("R5 after edge", 16'(irl_code), 16'(1 ^ 15));
    @(negedge clk); wr_en = 1; addr = 6'h00; wdata = 16'h0000;
    #1 chk("R5 mask write before edge", 16'(irl_code), 16'(1 ^ 15));
    @(posedge clk); #1 chk("R5 mask write after edge", 16'(irl_code), 0);
    @(negedge clk); wr_en = 0; req = 0;
    wr(6'h00, 16'hFFFF);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(6'h36, 16'hA5C3); rd(6'h36, d); chk("R6 gpo rw", d, 16'hA5C3);
    rd(6'h00, d); chk("R6 mask rw", d, 16'hFFFF);
    wr(6'h32, 16'h1234); rd(6'h32, d); chk("R8 id fixed", d, 16'h0010);
    rd(6'h30, d); chk("R7 pwr reads 0", d, 0);
    @(negedge clk); #1 chk("R10 rdata holds", rdata, 0);
    rd(6'h36, d);
    @(negedge clk); chk("R10 hold after read", rdata, 16'hA5C3);
  endtask

  task automatic t_unlisted();
    logic [15:0] d;
    set_req(13'(1) << 3);
    wr(6'h02, 16'h0000); wr(6'h34, 16'h0000); wr(6'h3E, 16'h0000);
    chk("R9 irl unchanged", 16'(irl_code), 16'(10 ^ 15));
    rd(6'h00, d); chk("R9 mask unchanged", d, 16'hFFFF);
    rd(6'h36, d); chk("R9 gpo unchanged", d, 16'hA5C3);
    rd(6'h02, d); chk("R9 read 0x02", d, 0);
    rd(6'h3E, d); chk("R9 read 0x3E", d, 0);
    set_req(0);
  endtask

  task automatic t_shutdown();
    @(negedge clk); wr_en = 1; addr = 6'h30; wdata = 16'h0001;
    @(posedge clk); #1 chk("R7 pulse high", 16'(shutdown), 1);
    @(negedge clk); wr_en = 0;
    @(posedge clk); #1 chk("R7 pulse one cycle", 16'(shutdown), 0);
    @(negedge clk); wr_en = 1; wdata = 16'h0002;
    @(posedge clk); #1 chk("R7 bit0 clear no pulse", 16'(shutdown), 0);
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_priority();
    t_timing();
    t_regs();
    t_unlisted();
    t_shutdown();
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule